// File: doc/BRIEF.md
# Error Report Capture and Readout

This block sits behind a frame-checking engine and holds the most recent error report it produced. Each report comes as a 32-bit CRC syndrome and a 67-bit message word, marked by a single-cycle valid strobe. The block stores both on the strobe. From the stored syndrome it drives an error flag. From the stored message it drives a decoded error class. The low four bits of the message word carry the error-type code. The remaining bits carry the error location, and the block passes them through unchanged.

Two readers can fetch the stored report independently: a test-access port and core user logic. Each reader has its own capture register and its own parallel-load serial shift register. The capture register takes the stored message one cycle after the strobe. A reader raises its hold input to freeze its capture register. While holding, it loads that register into its shift register and clocks the word out LSB first. A report that arrives while a path is held is not taken by that path. That path instead raises a sticky overrun bit, which stays set until the reader's next load.

Top module: `err_report_capture`

## Requirements
- R1: `err_flag_o` is 0 when the syndrome stored at the last strobe is all zeros and 1 otherwise. It changes at the clock edge that samples `rpt_valid_i` high.
- R2: `err_kind_o` decodes bits [3:0] of the stored message as follows: code 0000 gives 0 (no error), 0001 gives 1 (single bit), 0010 gives 2 (double adjacent), and every other code gives 3 (other).
- R3: The stored message and syndrome are rewritten at every edge where `rpt_valid_i` is 1, and hold their value at every other edge.
- R4: When a path's hold is low, its capture register takes the stored message at the edge one cycle after the strobe edge. Message bits above [3:0] reach the shift output unchanged.
- R5: A load pulse copies the capture register into the shift register only while that path's hold is 1. A load with hold at 0 leaves the shift register unchanged. Load takes priority over shift.
- R6: A shift pulse moves the shift register one place toward bit 0. The serial output is bit 0, and the serial input enters bit 66, so 66 shifts after a load present all 67 bits LSB first.
- R7: While a path's hold is 1, its capture register ignores new reports and keeps the report it had.
- R8: A report that reaches a held path sets that path's overrun bit. The bit stays set until a load is accepted on that path. If a new report and an accepted load fall in the same cycle, the overrun bit is set.
- R9: The test-access path and the user path have separate hold, load, shift and overrun state, and neither affects the other.
- R10: A synchronous active-high reset clears the stored report, both capture and shift registers, and both overrun bits, and drives the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| syndrome_i | input | 32 | CRC syndrome of the checked frame |
| rpt_msg_i | input | 67 | Error message word; bits [3:0] hold the type code |
| rpt_valid_i | input | 1 | Strobe marking syndrome and message valid |
| err_flag_o | output | 1 | High when the stored syndrome is non-zero |
| err_kind_o | output | 2 | Decoded error class: 0 none, 1 single, 2 double, 3 other |
| tap_hold_i | input | 1 | Test-access path: freeze the capture register and allow loads |
| tap_load_i | input | 1 | Test-access path: parallel load of the shift register |
| tap_shift_i | input | 1 | Test-access path: shift one place |
| tap_sin_i | input | 1 | Test-access path: serial data in |
| tap_sout_o | output | 1 | Test-access path: serial data out |
| tap_overrun_o | output | 1 | Test-access path: report lost while held |
| usr_hold_i | input | 1 | User path: freeze the capture register and allow loads |
| usr_load_i | input | 1 | User path: parallel load of the shift register |
| usr_shift_i | input | 1 | User path: shift one place |
| usr_sin_i | input | 1 | User path: serial data in |
| usr_sout_o | output | 1 | User path: serial data out |
| usr_overrun_o | output | 1 | User path: report lost while held |

## Verification
Two events can land on the same edge: the delayed capture of a new report, and a reader's accepted load, which clears the overrun bit. The bench raises a path's hold and clears that path's overrun with a full read. It then strobes a report and pulses load on the very next edge, where the delayed capture arrives. The check passes if the shifted-out bit is the old report's bit 0 and the overrun bit reads 1. A later read must return the old report, while the other path returns the new one.

// File: rtl/erc_pkg.sv
package erc_pkg;
  localparam int TYPE_W = 4;

  typedef enum logic [1:0] {
    EK_NONE   = 2'd0,
    EK_SINGLE = 2'd1,
    EK_DOUBLE = 2'd2,
    EK_OTHER  = 2'd3
  } err_kind_e;

  // maps the four-bit type code carried in the message word to a class
  function automatic err_kind_e classify(input logic [TYPE_W-1:0] code);
    err_kind_e k;
    case (code)
      4'b0000: k = EK_NONE;
      4'b0001: k = EK_SINGLE;
      4'b0010: k = EK_DOUBLE;
      default: k = EK_OTHER;
    endcase
    return k;
  endfunction

  // next shift register value: move toward bit 0, serial input enters at top
  function automatic logic [66:0] shift_one(input logic [66:0] cur, input logic sin);
    return {sin, cur[66:1]};
  endfunction
endpackage

// File: rtl/err_store.sv
module err_store
  import erc_pkg::*;
#(
  parameter int SYN_W = 32,
  parameter int MSG_W = 67
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYN_W-1:0] syn_i,
  input  logic [MSG_W-1:0] msg_i,
  input  logic             valid_i,
  output logic [MSG_W-1:0] msg_q_o,
  output logic             upd_o,
  output logic             flag_o,
  output err_kind_e        kind_o
);
  logic [SYN_W-1:0] syn_q;
  logic [MSG_W-1:0] msg_q;
  logic             upd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      syn_q <= '0;
      msg_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= valid_i;
      if (valid_i) begin
        syn_q <= syn_i;
        msg_q <= msg_i;
      end
    end
  end

  assign msg_q_o = msg_q;
  assign upd_o   = upd_q;
  assign flag_o  = |syn_q;
  assign kind_o  = classify(msg_q[TYPE_W-1:0]);

  // R1
  flag_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> (flag_o == ($past(syn_i) != '0)));

  // R3
  msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(msg_q) && $stable(syn_q)));
endmodule

// File: rtl/rd_path.sv
module rd_path
  import erc_pkg::*;
#(
  parameter int MSG_W = 67
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MSG_W-1:0] cap_data_i,
  input  logic             upd_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             sin_i,
  output logic             sout_o,
  output logic             overrun_o
);
  logic [MSG_W-1:0] cap_q;
  logic [MSG_W-1:0] sr_q;
  logic             ovr_q;

  // named events for the assertions
  logic cap_take;
  logic cap_block;
  logic sr_load;
  logic sr_shift;

  assign cap_take  = upd_i & ~hold_i;
  assign cap_block = upd_i &  hold_i;
  assign sr_load   = load_i & hold_i;
  assign sr_shift  = shift_i & ~sr_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
    end else if (cap_take) begin
      cap_q <= cap_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (sr_load) begin
      sr_q <= cap_q;
    end else if (sr_shift) begin
      sr_q <= shift_one(sr_q, sin_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_q <= 1'b0;
    end else if (cap_block) begin
      ovr_q <= 1'b1;
    end else if (sr_load) begin
      ovr_q <= 1'b0;
    end
  end

  assign sout_o    = sr_q[0];
  assign overrun_o = ovr_q;

  // R4
  cap_take_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && !hold_i) |=> (cap_q == $past(cap_data_i)));

  // R7
  cap_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(cap_q));

  // R5
  no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !hold_i && !shift_i) |=> $stable(sr_q));

  // R6
  sin_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !(load_i && hold_i)) |=> (sr_q[MSG_W-1] == $past(sin_i)));

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_i && hold_i) |=> overrun_o);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun_o && !(load_i && hold_i)) |=> overrun_o);
endmodule

// File: rtl/err_report_capture.sv
module err_report_capture
  import erc_pkg::*;
#(
  parameter int SYN_W = 32,
  parameter int MSG_W = 67
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYN_W-1:0] syndrome_i,
  input  logic [MSG_W-1:0] rpt_msg_i,
  input  logic             rpt_valid_i,
  output logic             err_flag_o,
  output logic [1:0]       err_kind_o,
  input  logic             tap_hold_i,
  input  logic             tap_load_i,
  input  logic             tap_shift_i,
  input  logic             tap_sin_i,
  output logic             tap_sout_o,
  output logic             tap_overrun_o,
  input  logic             usr_hold_i,
  input  logic             usr_load_i,
  input  logic             usr_shift_i,
  input  logic             usr_sin_i,
  output logic             usr_sout_o,
  output logic             usr_overrun_o
);
  localparam int NPATH = 2;

  logic [MSG_W-1:0] msg_q;
  logic             upd;
  err_kind_e        kind;

  logic [NPATH-1:0] hold_v, load_v, shift_v, sin_v, sout_v, ovr_v;

  err_store #(.SYN_W(SYN_W), .MSG_W(MSG_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .syn_i   (syndrome_i),
    .msg_i   (rpt_msg_i),
    .valid_i (rpt_valid_i),
    .msg_q_o (msg_q),
    .upd_o   (upd),
    .flag_o  (err_flag_o),
    .kind_o  (kind)
  );

  assign err_kind_o = kind;

  // index 0: test-access path, index 1: user path
  assign hold_v  = {usr_hold_i,  tap_hold_i};
  assign load_v  = {usr_load_i,  tap_load_i};
  assign shift_v = {usr_shift_i, tap_shift_i};
  assign sin_v   = {usr_sin_i,   tap_sin_i};

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    rd_path #(.MSG_W(MSG_W)) u_path (
      .clk        (clk),
      .rst        (rst),
      .cap_data_i (msg_q),
      .upd_i      (upd),
      .hold_i     (hold_v[g]),
      .load_i     (load_v[g]),
      .shift_i    (shift_v[g]),
      .sin_i      (sin_v[g]),
      .sout_o     (sout_v[g]),
      .overrun_o  (ovr_v[g])
    );
  end

  assign tap_sout_o    = sout_v[0];
  assign tap_overrun_o = ovr_v[0];
  assign usr_sout_o    = sout_v[1];
  assign usr_overrun_o = ovr_v[1];

  // R9
  path_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!tap_hold_i && usr_hold_i && upd) |=> (usr_overrun_o && $stable(tap_overrun_o)));
endmodule

// File: tb/err_report_capture_bench.sv
`timescale 1ns/1ps
module err_report_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] syn = '0;
  logic [66:0] msg = '0;
  logic        vld = 1'b0;
  logic        flag;
  logic [1:0]  kind;
  logic        hold [2];
  logic        load [2];
  logic        shft [2];
  logic        sin  [2];
  logic        sout [2];
  logic        ovr  [2];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  err_report_capture u_err_report_capture (
    .clk(clk), .rst(rst), .syndrome_i(syn), .rpt_msg_i(msg), .rpt_valid_i(vld),
    .err_flag_o(flag), .err_kind_o(kind),
    .tap_hold_i(hold[0]), .tap_load_i(load[0]), .tap_shift_i(shft[0]),
    .tap_sin_i(sin[0]), .tap_sout_o(sout[0]), .tap_overrun_o(ovr[0]),
    .usr_hold_i(hold[1]), .usr_load_i(load[1]), .usr_shift_i(shft[1]),
    .usr_sin_i(sin[1]), .usr_sout_o(sout[1]), .usr_overrun_o(ovr[1])
  );

  task automatic chk(input bit ok, input string req, input logic [133:0] act, input logic [133:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [66:0] mk_msg(input int n, input logic [3:0] code);
    logic [66:0] m;
    for (int b = 0; b < 67; b++) m[b] = (((n * 13) + (b * b * 7)) % 11) > 4;
    m[3:0] = code;
    return m;
  endfunction

  function automatic logic [1:0] exp_kind(input logic [3:0] c);
    if (c == 4'd0) return 2'd0;
    if (c == 4'd1) return 2'd1;
    if (c == 4'd2) return 2'd2;
    return 2'd3;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // strobe one report; returns at the negedge after the strobe edge
  task automatic send(input logic [31:0] s, input logic [66:0] m);
    syn = s; msg = m; vld = 1'b1;
    @(posedge clk); @(negedge clk);
    vld = 1'b0; syn = '0; msg = '0;
  endtask

  // hold, load, then nshift shifts with serial input pat; leaves hold high
  task automatic read_path(input int p, input int nshift, input logic [133:0] pat,
                           output logic [133:0] got);
    got = '0;
    hold[p] = 1'b1; load[p] = 1'b1;
    @(posedge clk); @(negedge clk);
    load[p] = 1'b0;
    got[0] = sout[p];
    for (int i = 1; i <= nshift; i++) begin
      shft[p] = 1'b1; sin[p] = pat[i-1];
      @(posedge clk); @(negedge clk);
      got[i] = sout[p];
    end
    shft[p] = 1'b0; sin[p] = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [133:0] got;
    logic [66:0]  m, old_m, new_m;
    logic [31:0]  s;
    logic         bit0;
    for (int p = 0; p < 2; p++) begin
      hold[p] = 0; load[p] = 0; shft[p] = 0; sin[p] = 0;
    end
    @(negedge clk); idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk(flag == 1'b0, "R10 flag", 134'(flag), 134'(0));
    chk(kind == 2'd0, "R10 kind", 134'(kind), 134'(0));
    chk(ovr[0] == 0 && ovr[1] == 0, "R10 overrun", 134'({ovr[1], ovr[0]}), 134'(0));
    read_path(0, 66, '0, got);
    chk(got[66:0] == '0, "R10 tap capture", got, '0);
    hold[0] = 0; idle(1);

    // R1 R2 R3 R4 R6 sweep over every type code
    for (int c = 0; c < 16; c++) begin
      m = mk_msg(c, 4'(c));
      s = (c % 3 == 0) ? 32'd0 : (32'd1 << (c * 2));
      send(s, m);
      chk(flag == (s != 0), "R1 flag", 134'(flag), 134'(s != 0));
      chk(kind == exp_kind(4'(c)), "R2 kind", 134'(kind), 134'(exp_kind(4'(c))));
      idle(2);
      chk(kind == exp_kind(4'(c)), "R3 hold", 134'(kind), 134'(exp_kind(4'(c))));
      read_path(0, 66, '0, got);
      chk(got[66:0] == m, "R4 R6 tap word", got, 134'(m));
      hold[0] = 0;
      if (c % 4 == 1) begin
        read_path(1, 66, '0, got);
        chk(got[66:0] == m, "R4 R9 usr word", got, 134'(m));
        hold[1] = 0;
      end
      idle(1);
    end

    // R6 serial input reaches the output after the word
    m = mk_msg(40, 4'd1);
    send(32'h5, m); idle(2);
    read_path(0, 133, 134'h2AAAA_BEEF_1234_5678_9ABC_DEF0, got);
    chk(got[66:0] == m, "R6 word", got, 134'(m));
    chk(got[133:67] == 67'(134'h2AAAA_BEEF_1234_5678_9ABC_DEF0), "R6 sin",
        134'(got[133:67]), 134'(67'(134'h2AAAA_BEEF_1234_5678_9ABC_DEF0)));
    hold[0] = 0; idle(1);

    // R5 load without hold ignored
    m = mk_msg(7, 4'd2); m[66] = 1'b1;
    send(32'h1, m); idle(2);
    read_path(0, 66, '0, got);
    hold[0] = 0;
    chk(sout[0] == 1'b1, "R5 pre", 134'(sout[0]), 134'(1));
    load[0] = 1'b1; @(posedge clk); @(negedge clk); load[0] = 1'b0;
    chk(sout[0] == 1'b1, "R5 ignored load", 134'(sout[0]), 134'(1));
    shft[0] = 1'b1; @(posedge clk); @(negedge clk); shft[0] = 1'b0;
    chk(sout[0] == 1'b0, "R5 after shift", 134'(sout[0]), 134'(0));

    // R7 R8 R9 report arrives while the tap path is held
    old_m = m;
    new_m = mk_msg(99, 4'hF);
    hold[0] = 1'b1;
    send(32'h0, new_m); idle(1);
    chk(ovr[0] == 1'b1, "R8 tap overrun set", 134'(ovr[0]), 134'(1));
    chk(ovr[1] == 1'b0, "R9 usr no overrun", 134'(ovr[1]), 134'(0));
    chk(flag == 1'b0, "R1 zero syndrome", 134'(flag), 134'(0));
    idle(3);
    chk(ovr[0] == 1'b1, "R8 sticky", 134'(ovr[0]), 134'(1));
    read_path(0, 66, '0, got);
    chk(got[66:0] == old_m, "R7 kept old", got, 134'(old_m));
    chk(ovr[0] == 1'b0, "R8 cleared by load", 134'(ovr[0]), 134'(0));
    read_path(1, 66, '0, got);
    chk(got[66:0] == new_m, "R9 usr new", got, 134'(new_m));
    hold[1] = 0;

    // R8 new report and accepted load on the same edge
    m = mk_msg(55, 4'd1);
    syn = 32'h80; msg = m; vld = 1'b1;
    @(posedge clk); @(negedge clk);
    vld = 1'b0; load[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    load[0] = 1'b0;
    bit0 = old_m[0];
    chk(ovr[0] == 1'b1, "R8 set wins", 134'(ovr[0]), 134'(1));
    chk(sout[0] == bit0, "R7 R8 old bit0", 134'(sout[0]), 134'(bit0));
    hold[0] = 0; idle(2);
    read_path(0, 66, '0, got);
    chk(got[66:0] == old_m, "R7 still old", got, 134'(old_m));
    hold[0] = 0;
    read_path(1, 66, '0, got);
    chk(got[66:0] == m, "R9 usr latest", got, 134'(m));
    hold[1] = 0;

    // R10 reset mid-run
    rst = 1'b1; idle(2); rst = 1'b0; @(negedge clk);
    chk(flag == 1'b0 && ovr[0] == 1'b0, "R10 re-reset", 134'({flag, ovr[0]}), 134'(0));
    read_path(1, 66, '0, got);
    chk(got[66:0] == '0, "R10 usr cleared", got, '0);
    hold[1] = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule